// File: doc/BRIEF.md
# Line Mode and Protection Controller

This block sits between the control register fields of a telephone line interface and the analog line circuitry. It turns a handful of programmed bits, plus a digitized sample of the automatic-gain-control current, into the decisions the analog side acts on. Those decisions are which DC regulation mask is in force, the start and stop points of the gain-control window, whether the long-line sidetone path is used, whether the line driver may run, and the gain range to report.

A second job is overload protection. While a current-regulation mask is active and the line is held, a gain-control current at or above a ratio-dependent trip level for a long enough run of millisecond ticks latches a protection flag. Only an on-hook then off-hook cycle of the hook-switch bit clears that flag. The analog regulation, the gain curves and the serial port that loads the fields are outside this block.

All decoded outputs are registered once. The protection flag comes from a tick counter and a latch.

Top module: `lnif_mode_ctrl`

## Requirements
- R1: When `dial_mode` is 1, `mask_code` becomes 2'b01 (pulse-dial mask) one clock later, whatever `dc_mask_cur` and `agc_ratio` hold.
- R2: When `dial_mode` is 0, `mask_code` becomes, one clock later, 2'b00 (voltage regulation) if `dc_mask_cur` is 0. It becomes 2'b10 (current regulation, ratio 1:2) if `dc_mask_cur` is 1 and `agc_ratio` is 0, and 2'b11 (current regulation, ratio 3:5) if both are 1.
- R3: One clock after the inputs, `agc_start_ua`/`agc_stop_ua` are set by {`dc_mask_cur`,`agc_ratio`}, independent of `dial_mode`: 00 gives 10/31, 01 gives 21/42, 10 gives 21/42, 11 gives 31/52.
- R4: `prot_flag` sets at the clock edge that samples the TRIP_TICKS-th consecutive qualifying `tick_ms` (default 800). A tick qualifies when `dial_mode`=0, `dc_mask_cur`=1, `hook_bit`=1 and `agc_ua` is at least the trip level. The trip level is 52 for `agc_ratio`=0 and 62 for `agc_ratio`=1. A level one below the trip level never sets the flag.
- R5: The tick count restarts from zero in any cycle where the trip condition is not met, including when the mask is not current regulation. After such a break, a full TRIP_TICKS further qualifying ticks are needed.
- R6: Once set, `prot_flag` stays 1 while `hook_bit` stays 1. It clears at the first edge that samples `hook_bit`=1 after at least one edge that sampled `hook_bit`=0.
- R7: `driver_en` equals the `hook_bit` sampled at the previous edge, so a low hook-switch bit turns the driver off one clock later.
- R8: With `pabx_mode`=0, `long_path_en` is 1 one clock later exactly when 2×`agc_ua` ≥ start+stop of the current window (R3).
- R9: With `pabx_mode`=1, `long_path_en` is 0 one clock later for any current.
- R10: `gain_range_db` is 0 one clock after `agc_range_off`=1 and 6 after `agc_range_off`=0.
- R11: During reset the outputs hold the all-zero-field decode: `mask_code`=00, window 10/31, `long_path_en`=0, `driver_en`=0, `gain_range_db`=6, `prot_flag`=0, and the tick count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hook_bit | input | 1 | Hook-switch control bit, 1 = off-hook |
| dial_mode | input | 1 | Low-drop dialing mode field |
| dc_mask_cur | input | 1 | DC mask field, 1 = current regulation |
| agc_ratio | input | 1 | Gain-control ratio field |
| pabx_mode | input | 1 | 1 = short-line input only |
| agc_range_off | input | 1 | 1 = gain-control range switched off |
| agc_ua | input | AGC_W | Gain-control current sample in µA |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| mask_code | output | 2 | Selected DC mask code |
| agc_start_ua | output | AGC_W | Gain-control window start, µA |
| agc_stop_ua | output | AGC_W | Gain-control window stop, µA |
| long_path_en | output | 1 | Long-line sidetone path select |
| driver_en | output | 1 | Line driver enable |
| gain_range_db | output | GAIN_W | Reported gain range in dB |
| prot_flag | output | 1 | Latched protection mode |

## Verification
Mask code, window, sidetone select, driver enable and gain range are due one clock after the inputs that set them. The bench drives on the falling edge and compares at the following falling edge, with exactly one rising edge in between. The protection flag is due at the edge that samples the last qualifying tick, so the bench checks it one falling edge after raising that tick, both at TRIP_TICKS−1 ticks and at TRIP_TICKS ticks. Clearing is checked one falling edge after the hook bit returns high, and again while the hook bit is still low, where the flag must persist.

// File: rtl/lnif_pkg.sv
package lnif_pkg;

  typedef enum logic [1:0] {
    MASK_VREG    = 2'b00,
    MASK_PULSE   = 2'b01,
    MASK_CREG_12 = 2'b10,
    MASK_CREG_35 = 2'b11
  } dc_mask_e;

  localparam int TRIP_UA_LOW  = 52;
  localparam int TRIP_UA_HIGH = 62;
  localparam int GAIN_FULL_DB = 6;

  // dialing mode wins over every other field
  function automatic dc_mask_e pick_mask(input logic dial, input logic cur,
                                         input logic ratio);
    if (dial)       return MASK_PULSE;
    else if (!cur)  return MASK_VREG;
    else if (ratio) return MASK_CREG_35;
    else            return MASK_CREG_12;
  endfunction

  function automatic int window_start(input logic cur, input logic ratio);
    case ({cur, ratio})
      2'b00:   return 10;
      2'b01:   return 21;
      2'b10:   return 21;
      default: return 31;
    endcase
  endfunction

  function automatic int window_stop(input logic cur, input logic ratio);
    case ({cur, ratio})
      2'b00:   return 31;
      2'b01:   return 42;
      2'b10:   return 42;
      default: return 52;
    endcase
  endfunction

  function automatic int trip_level(input logic ratio);
    return ratio ? TRIP_UA_HIGH : TRIP_UA_LOW;
  endfunction

  // compare against the midpoint without a fraction: 2*I >= start+stop
  function automatic logic at_or_above_mid(input int cur_ua, input int start_ua,
                                           input int stop_ua);
    return (2 * cur_ua) >= (start_ua + stop_ua);
  endfunction

  function automatic int gain_range_of(input logic range_off);
    return range_off ? 0 : GAIN_FULL_DB;
  endfunction

endpackage

// File: rtl/lnif_mask_sel.sv
module lnif_mask_sel
  import lnif_pkg::*;
(
  input  logic     dial_mode,
  input  logic     dc_mask_cur,
  input  logic     agc_ratio,
  output dc_mask_e mask_sel,
  output logic     creg_sel
);
  assign mask_sel = pick_mask(dial_mode, dc_mask_cur, agc_ratio);
  assign creg_sel = (mask_sel == MASK_CREG_12) || (mask_sel == MASK_CREG_35);
endmodule

// File: rtl/lnif_agc_map.sv
module lnif_agc_map
  import lnif_pkg::*;
#(
  parameter int AGC_W = 8
) (
  input  logic             dc_mask_cur,
  input  logic             agc_ratio,
  input  logic             pabx_mode,
  input  logic [AGC_W-1:0] agc_ua,
  output logic [AGC_W-1:0] start_ua,
  output logic [AGC_W-1:0] stop_ua,
  output logic             long_sel
);
  int start_i;
  int stop_i;

  always_comb begin
    start_i  = window_start(dc_mask_cur, agc_ratio);
    stop_i   = window_stop(dc_mask_cur, agc_ratio);
    start_ua = AGC_W'(start_i);
    stop_ua  = AGC_W'(stop_i);
    long_sel = !pabx_mode && at_or_above_mid(int'(agc_ua), start_i, stop_i);
  end
endmodule

// File: rtl/lnif_prot_timer.sv
module lnif_prot_timer
  import lnif_pkg::*;
#(
  parameter int AGC_W      = 8,
  parameter int TRIP_TICKS = 800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             agc_ratio,
  input  logic             hook_bit,
  input  logic [AGC_W-1:0] agc_ua,
  input  logic             tick_ms,
  output logic             over_lvl,
  output logic             trip_evt,
  output logic             prot_flag
);
  localparam int CNT_W = (TRIP_TICKS > 1) ? $clog2(TRIP_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TRIP_TICKS - 1);

  logic [CNT_W-1:0] tick_cnt;
  logic             clr_pend;

  assign over_lvl = armed && hook_bit && !prot_flag &&
                    (int'(agc_ua) >= trip_level(agc_ratio));
  assign trip_evt = over_lvl && tick_ms && (tick_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_flag <= 1'b0;
      clr_pend  <= 1'b0;
      tick_cnt  <= '0;
    end else if (prot_flag) begin
      tick_cnt <= '0;
      if (!hook_bit) begin
        clr_pend <= 1'b1;
      end else if (clr_pend) begin
        prot_flag <= 1'b0;
        clr_pend  <= 1'b0;
      end
    end else begin
      clr_pend <= 1'b0;
      if (!over_lvl) begin
        tick_cnt <= '0;
      end else if (tick_ms) begin
        if (trip_evt) begin
          prot_flag <= 1'b1;
          tick_cnt  <= '0;
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lnif_mode_ctrl.sv
module lnif_mode_ctrl
  import lnif_pkg::*;
#(
  parameter int AGC_W      = 8,
  parameter int TRIP_TICKS = 800,
  parameter int GAIN_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hook_bit,
  input  logic              dial_mode,
  input  logic              dc_mask_cur,
  input  logic              agc_ratio,
  input  logic              pabx_mode,
  input  logic              agc_range_off,
  input  logic [AGC_W-1:0]  agc_ua,
  input  logic              tick_ms,
  output logic [1:0]        mask_code,
  output logic [AGC_W-1:0]  agc_start_ua,
  output logic [AGC_W-1:0]  agc_stop_ua,
  output logic              long_path_en,
  output logic              driver_en,
  output logic [GAIN_W-1:0] gain_range_db,
  output logic              prot_flag
);
  dc_mask_e         mask_nxt;
  logic             creg_sel;
  logic [AGC_W-1:0] start_nxt;
  logic [AGC_W-1:0] stop_nxt;
  logic             long_nxt;
  logic             over_lvl;
  logic             trip_evt;

  lnif_mask_sel u_mask (
    .dial_mode   (dial_mode),
    .dc_mask_cur (dc_mask_cur),
    .agc_ratio   (agc_ratio),
    .mask_sel    (mask_nxt),
    .creg_sel    (creg_sel)
  );

  lnif_agc_map #(.AGC_W(AGC_W)) u_map (
    .dc_mask_cur (dc_mask_cur),
    .agc_ratio   (agc_ratio),
    .pabx_mode   (pabx_mode),
    .agc_ua      (agc_ua),
    .start_ua    (start_nxt),
    .stop_ua     (stop_nxt),
    .long_sel    (long_nxt)
  );

  lnif_prot_timer #(.AGC_W(AGC_W), .TRIP_TICKS(TRIP_TICKS)) u_prot (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (creg_sel),
    .agc_ratio (agc_ratio),
    .hook_bit  (hook_bit),
    .agc_ua    (agc_ua),
    .tick_ms   (tick_ms),
    .over_lvl  (over_lvl),
    .trip_evt  (trip_evt),
    .prot_flag (prot_flag)
  );

  // decoded outputs: one register stage, reset to the all-zero-field decode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_code     <= MASK_VREG;
      agc_start_ua  <= AGC_W'(window_start(1'b0, 1'b0));
      agc_stop_ua   <= AGC_W'(window_stop(1'b0, 1'b0));
      long_path_en  <= 1'b0;
      driver_en     <= 1'b0;
      gain_range_db <= GAIN_W'(gain_range_of(1'b0));
    end else begin
      mask_code     <= mask_nxt;
      agc_start_ua  <= start_nxt;
      agc_stop_ua   <= stop_nxt;
      long_path_en  <= long_nxt;
      driver_en     <= hook_bit;
      gain_range_db <= GAIN_W'(gain_range_of(agc_range_off));
    end
  end
endmodule

// File: rtl/lnif_mode_chk.sv
module lnif_mode_chk #(
  parameter int AGC_W  = 8,
  parameter int GAIN_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hook_bit,
  input logic              dial_mode,
  input logic              dc_mask_cur,
  input logic              pabx_mode,
  input logic              agc_range_off,
  input logic [AGC_W-1:0]  agc_ua,
  input logic              tick_ms,
  input logic [1:0]        mask_code,
  input logic [AGC_W-1:0]  agc_start_ua,
  input logic [AGC_W-1:0]  agc_stop_ua,
  input logic              long_path_en,
  input logic              driver_en,
  input logic [GAIN_W-1:0] gain_range_db,
  input logic              prot_flag,
  input logic              trip_evt
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  p_dial_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(dial_mode)) |-> (mask_code == 2'b01));

  p_creg_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(dial_mode) && $past(dc_mask_cur)) |-> mask_code[1]);

  p_window_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (agc_start_ua < agc_stop_ua));

  p_trip_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_flag) |-> ($past(tick_ms) && $past(hook_bit) && !$past(dial_mode)
                          && $past(dc_mask_cur) && (int'($past(agc_ua)) >= 52)));

  p_trip_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |=> prot_flag);

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_flag && hook_bit && $past(hook_bit)) |=> prot_flag);

  p_driver_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(hook_bit)) |-> !driver_en);

  p_pabx_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(pabx_mode)) |-> !long_path_en);

  p_gain_flat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(agc_range_off)) |-> (gain_range_db == '0));
endmodule

bind lnif_mode_ctrl lnif_mode_chk #(.AGC_W(AGC_W), .GAIN_W(GAIN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hook_bit      (hook_bit),
  .dial_mode     (dial_mode),
  .dc_mask_cur   (dc_mask_cur),
  .pabx_mode     (pabx_mode),
  .agc_range_off (agc_range_off),
  .agc_ua        (agc_ua),
  .tick_ms       (tick_ms),
  .mask_code     (mask_code),
  .agc_start_ua  (agc_start_ua),
  .agc_stop_ua   (agc_stop_ua),
  .long_path_en  (long_path_en),
  .driver_en     (driver_en),
  .gain_range_db (gain_range_db),
  .prot_flag     (prot_flag),
  .trip_evt      (trip_evt)
);

// File: tb/lnif_mode_ctrl_tb.sv
module lnif_mode_ctrl_tb_top;
  localparam int AGC_W  = 8;
  localparam int TICKS  = 800;
  localparam int GAIN_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              hook_bit = 1'b0;
  logic              dial_mode = 1'b0;
  logic              dc_mask_cur = 1'b0;
  logic              agc_ratio = 1'b0;
  logic              pabx_mode = 1'b0;
  logic              agc_range_off = 1'b0;
  logic [AGC_W-1:0]  agc_ua = '0;
  logic              tick_ms = 1'b0;
  logic [1:0]        mask_code;
  logic [AGC_W-1:0]  agc_start_ua;
  logic [AGC_W-1:0]  agc_stop_ua;
  logic              long_path_en;
  logic              driver_en;
  logic [GAIN_W-1:0] gain_range_db;
  logic              prot_flag;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  lnif_mode_ctrl #(.AGC_W(AGC_W), .TRIP_TICKS(TICKS), .GAIN_W(GAIN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .hook_bit(hook_bit), .dial_mode(dial_mode),
    .dc_mask_cur(dc_mask_cur), .agc_ratio(agc_ratio), .pabx_mode(pabx_mode),
    .agc_range_off(agc_range_off), .agc_ua(agc_ua), .tick_ms(tick_ms),
    .mask_code(mask_code), .agc_start_ua(agc_start_ua), .agc_stop_ua(agc_stop_ua),
    .long_path_en(long_path_en), .driver_en(driver_en),
    .gain_range_db(gain_range_db), .prot_flag(prot_flag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1;
      step(1);
      tick_ms = 1'b0;
      step(gap);
    end
  endtask

  // bench's own view of the window table (R3)
  function automatic int exp_start(input logic c, input logic r);
    if (!c && !r) return 10;
    if (c && r)   return 31;
    return 21;
  endfunction
  function automatic int exp_stop(input logic c, input logic r);
    return exp_start(c, r) + 21;
  endfunction

  task automatic set_fields(input logic d, input logic c, input logic r);
    dial_mode = d; dc_mask_cur = c; agc_ratio = r;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    hook_bit = 1'b1; dial_mode = 1'b1; dc_mask_cur = 1'b1; agc_ratio = 1'b1;
    pabx_mode = 1'b0; agc_range_off = 1'b1; agc_ua = 8'd200;
    step(3);
    chk("R11", "mask_code", mask_code, 0);
    chk("R11", "start", agc_start_ua, 10);
    chk("R11", "stop", agc_stop_ua, 31);
    chk("R11", "long_path_en", long_path_en, 0);
    chk("R11", "driver_en", driver_en, 0);
    chk("R11", "gain_range_db", gain_range_db, 6);
    chk("R11", "prot_flag", prot_flag, 0);
    set_fields(0, 0, 0); hook_bit = 1'b0; agc_range_off = 1'b0; agc_ua = '0;
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_mask_select;
    for (int v = 0; v < 8; v++) begin
      int expc;
      set_fields(v[2], v[1], v[0]);
      step(1);
      if (v[2])      expc = 1;
      else if (!v[1]) expc = 0;
      else           expc = v[0] ? 3 : 2;
      chk(v[2] ? "R1" : "R2", "mask_code", mask_code, expc);
      chk("R3", "start", agc_start_ua, exp_start(v[1], v[0]));
      chk("R3", "stop", agc_stop_ua, exp_stop(v[1], v[0]));
    end
  endtask

  task automatic t_sidetone;
    pabx_mode = 1'b0;
    set_fields(0, 0, 0); agc_ua = 8'd21; step(1);
    chk("R8", "long at 21 (10/31)", long_path_en, 1);
    agc_ua = 8'd20; step(1);
    chk("R8", "long at 20 (10/31)", long_path_en, 0);
    set_fields(0, 1, 1); agc_ua = 8'd42; step(1);
    chk("R8", "long at 42 (31/52)", long_path_en, 1);
    agc_ua = 8'd41; step(1);
    chk("R8", "long at 41 (31/52)", long_path_en, 0);
    set_fields(1, 0, 1); agc_ua = 8'd32; step(1);
    chk("R8", "long at 32 (21/42, dialing)", long_path_en, 1);
    pabx_mode = 1'b1; agc_ua = 8'd200; step(1);
    chk("R9", "long with pabx", long_path_en, 0);
    set_fields(0, 0, 0); agc_ua = 8'd90; step(1);
    chk("R9", "long with pabx, vreg", long_path_en, 0);
    pabx_mode = 1'b0; agc_ua = '0; step(1);
  endtask

  task automatic t_gain_driver;
    agc_range_off = 1'b1; step(1);
    chk("R10", "gain range off", gain_range_db, 0);
    agc_range_off = 1'b0; step(1);
    chk("R10", "gain range on", gain_range_db, 6);
    hook_bit = 1'b1; step(1);
    chk("R7", "driver_en hook high", driver_en, 1);
    hook_bit = 1'b0; step(1);
    chk("R7", "driver_en hook low", driver_en, 0);
    hook_bit = 1'b1; step(1);
  endtask

  task automatic clear_prot;
    agc_ua = '0;
    hook_bit = 1'b0; step(2);
    chk("R6", "flag held while on-hook", prot_flag, 1);
    chk("R7", "driver off while on-hook", driver_en, 0);
    hook_bit = 1'b1; step(1);
    chk("R6", "flag cleared after hook cycle", prot_flag, 0);
  endtask

  task automatic t_trip_low_ratio;
    hook_bit = 1'b1; set_fields(0, 1, 0);
    agc_ua = 8'd51; ticks(TICKS + 50, 0);
    chk("R4", "no trip at 51 ratio 1:2", prot_flag, 0);
    agc_ua = 8'd52; ticks(TICKS - 1, 1);
    chk("R4", "no trip after TICKS-1", prot_flag, 0);
    tick_ms = 1'b1; step(1); tick_ms = 1'b0;
    chk("R4", "trip at TICKS, 52 ratio 1:2", prot_flag, 1);
    step(10);
    chk("R6", "flag held hook high", prot_flag, 1);
    clear_prot();
  endtask

  task automatic t_trip_high_ratio;
    hook_bit = 1'b1; set_fields(0, 1, 1);
    agc_ua = 8'd61; ticks(TICKS + 20, 0);
    chk("R4", "no trip at 61 ratio 3:5", prot_flag, 0);
    agc_ua = 8'd62; ticks(TICKS, 0);
    chk("R4", "trip at 62 ratio 3:5", prot_flag, 1);
    clear_prot();
  endtask

  task automatic t_dropout;
    hook_bit = 1'b1; set_fields(0, 1, 0); agc_ua = 8'd70;
    ticks(500, 0);
    agc_ua = 8'd40; step(1);
    agc_ua = 8'd70;
    ticks(TICKS - 1, 0);
    chk("R5", "count restarted after dropout", prot_flag, 0);
    ticks(1, 0);
    chk("R5", "trip after full run post-dropout", prot_flag, 1);
    clear_prot();
    set_fields(0, 0, 0); agc_ua = 8'd120;
    ticks(TICKS + 20, 0);
    chk("R5", "no trip in voltage mask", prot_flag, 0);
    set_fields(1, 1, 0);
    ticks(TICKS + 20, 0);
    chk("R5", "no trip in dialing mask", prot_flag, 0);
    agc_ua = '0; set_fields(0, 0, 0); step(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_mask_select();
    t_sidetone();
    t_gain_driver();
    t_trip_low_ratio();
    t_trip_high_ratio();
    t_dropout();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule